// File: doc/BRIEF.md
# Virtual-8086 Address Translation Unit

This unit turns a legacy segment:offset pair into a physical address for an 8086-style task that runs on a paging processor. The segment value is shifted left by four bits and the offset is added, which gives a 20-bit linear address that wraps within 1 MB. The unit checks the offset against the 64 KB segment limit, taking the access size into account. It then relocates the linear page through a page-mapping table with one entry per linear page. That gives 256 pages of 4 KB, and each page can be placed in any 4 KB frame of the 32-bit physical space.

The operating system loads the table one entry at a time through a refill port. A write strobe for the page-directory base register empties the whole table, so the mappings of one task are never used by the next task. Each accepted request produces one registered response on the following cycle. The response either carries a physical address, or reports a general-protection fault, or reports a page fault with a two-bit access-type code.

Top module: `v86_xlate_unit`

## Requirements
- R1: The linear address is (segment × 16 + offset) modulo 2^20. A successful response carries rsp_paddr = {frame of page linear[19:12], linear[11:0]}, where the frame is the 20-bit value last loaded for that page.
- R2: req_size holds the byte count minus one (0 = 1 byte, 1 = 2, 2 = 3, 3 = 4). When offset + req_size exceeds 0xFFFF, the response raises rsp_gp. It then raises neither rsp_pf nor rsp_pa_ok, and this holds even when the page is mapped.
- R3: A request to a page that was never loaded, was flushed, or was last loaded with present = 0 raises rsp_pf. rsp_pf_code is {U/S, W/R}, with bit 1 = user and bit 0 = write: 00 supervisor read, 01 supervisor write, 10 user read, 11 user write.
- R4: A request with req_desc = 1 reports U/S = 0 (rsp_pf_code[1] = 0) on a page fault, even when req_user = 1.
- R5: A cr3_wr pulse invalidates every entry. A request in the same cycle as cr3_wr misses, and a refill in the same cycle as cr3_wr is discarded.
- R6: A refill is written at the clock edge that samples it. A request in the same cycle sees the old entry, and a request in the next cycle sees the new one.
- R7: rsp_valid is high exactly in the cycle after a cycle with req_valid. Outside a valid response all flags are 0. rsp_pa_ok is high only when there is no fault, and rsp_paddr and rsp_pf_code are 0 unless their result is reported.
- R8: During and after reset all response outputs are 0 and every table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Effective offset |
| req_size | input | 2 | Access byte count minus one |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user privilege |
| req_desc | input | 1 | 1 = descriptor-table access |
| fill_valid | input | 1 | Refill strobe |
| fill_page | input | 8 | Linear page index to load |
| fill_frame | input | 20 | Physical frame number |
| fill_present | input | 1 | Present bit of the loaded entry |
| cr3_wr | input | 1 | Page-directory base write strobe (flush) |
| rsp_valid | output | 1 | Response present |
| rsp_pa_ok | output | 1 | Physical address valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_gp | output | 1 | General-protection fault (exception 13) |
| rsp_pf | output | 1 | Page fault |
| rsp_pf_code | output | 2 | {U/S, W/R} access-type code |

## Verification
The bench builds the unit with its default parameters: 16-bit segment and offset, a shift of four, a 12-bit page, a 32-bit physical space and a 2-bit size field. This gives the full 256-entry table. It also makes the corner cases reachable: the 1 MB wrap from segment 0xFFFF, the all-ones frame 0xFFFFF, and offsets where a 1-, 2- or 4-byte access just fits or just crosses 0xFFFF. Same-cycle interactions between refill, flush and request are driven directly, so the ordering rules of the table can be observed at the response.

// File: rtl/v86_xlate_pkg.sv
package v86_xlate_pkg;

   localparam int DEF_SEG_W     = 16;
   localparam int DEF_OFF_W     = 16;
   localparam int DEF_SEG_SHIFT = 4;
   localparam int DEF_SIZE_W    = 2;
   localparam int DEF_PAGE_W    = 12;
   localparam int DEF_PHYS_W    = 32;

   // Access-type code reported with a page fault: {U/S, W/R}.
   // Descriptor-table accesses are always reported as supervisor.
   function automatic logic [1:0] pf_access_code(input logic user,
                                                 input logic desc,
                                                 input logic write);
      return {user & ~desc, write};
   endfunction

endpackage

// File: rtl/v86_lin_former.sv
module v86_lin_former #(
   parameter int SEG_W     = 16,
   parameter int OFF_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int SIZE_W    = 2,
   parameter int LIN_W     = 20
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   input  logic [SIZE_W-1:0] size_m1,
   output logic [LIN_W-1:0]  lin,
   output logic              limit_err
);

   localparam int SUM_W = OFF_W + 1;

   if (LIN_W != SEG_W + SEG_SHIFT) begin : g_bad_lin
      $error("v86_lin_former: LIN_W must equal SEG_W + SEG_SHIFT");
   end
   if (SIZE_W > OFF_W) begin : g_bad_size
      $error("v86_lin_former: SIZE_W must not exceed OFF_W");
   end

   logic [LIN_W-1:0] seg_base;
   logic [SUM_W-1:0] last_byte;

   // Segment shifted into a paragraph base; the carry out of the top bit
   // is dropped so the linear address wraps inside the linear space.
   assign seg_base  = {seg, {SEG_SHIFT{1'b0}}};
   assign lin       = seg_base + LIN_W'(off);

   // Offset of the last byte touched; a carry means the limit is crossed.
   assign last_byte = {1'b0, off} + SUM_W'(size_m1);
   assign limit_err = last_byte[OFF_W];

endmodule

// File: rtl/v86_page_cache.sv
module v86_page_cache #(
   parameter int PAGES_W = 8,
   parameter int FRAME_W = 20,
   localparam int NUM_PAGES = 1 << PAGES_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               fill_en,
   input  logic [PAGES_W-1:0] fill_idx,
   input  logic [FRAME_W-1:0] fill_frame,
   input  logic               fill_present,
   input  logic [PAGES_W-1:0] rd_idx,
   output logic               rd_hit,
   output logic [FRAME_W-1:0] rd_frame
);

   if (PAGES_W < 1 || PAGES_W > 12) begin : g_bad_depth
      $error("v86_page_cache: PAGES_W out of supported range");
   end

   logic [NUM_PAGES-1:0] vld_q;
   logic [FRAME_W-1:0]   frame_mem [NUM_PAGES];

   // Usable bit per page: set by a present refill, cleared by an absent
   // refill or by a flush. A flush wins over a refill in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (flush) begin
         vld_q <= '0;
      end else if (fill_en) begin
         vld_q[fill_idx] <= fill_present;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en && !flush) begin
         frame_mem[fill_idx] <= fill_frame;
      end
   end

   // A flush in the current cycle already hides every entry.
   assign rd_hit   = vld_q[rd_idx] & ~flush;
   assign rd_frame = frame_mem[rd_idx];

   // R5: after a flush edge no entry remains usable
   assert_flush_empty_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld_q == '0));

   // R6: a refill without flush is visible on the next cycle
   assert_fill_visible_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !flush && fill_present) |=> (vld_q != '0));

endmodule

// File: rtl/v86_rsp_stage.sv
module v86_rsp_stage #(
   parameter int PHYS_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              limit_err,
   input  logic              hit,
   input  logic [PHYS_W-1:0] paddr_in,
   input  logic              user,
   input  logic              desc,
   input  logic              write,
   output logic              rsp_valid,
   output logic              rsp_pa_ok,
   output logic [PHYS_W-1:0] rsp_paddr,
   output logic              rsp_gp,
   output logic              rsp_pf,
   output logic [1:0]        rsp_pf_code
);

   import v86_xlate_pkg::*;

   logic take_gp, take_pf, take_ok;

   // Limit violation outranks any table outcome.
   assign take_gp = req_valid & limit_err;
   assign take_pf = req_valid & ~limit_err & ~hit;
   assign take_ok = req_valid & ~limit_err & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_pa_ok   <= 1'b0;
         rsp_paddr   <= '0;
         rsp_gp      <= 1'b0;
         rsp_pf      <= 1'b0;
         rsp_pf_code <= 2'b00;
      end else begin
         rsp_valid   <= req_valid;
         rsp_gp      <= take_gp;
         rsp_pf      <= take_pf;
         rsp_pa_ok   <= take_ok;
         rsp_paddr   <= take_ok ? paddr_in : '0;
         rsp_pf_code <= take_pf ? pf_access_code(user, desc, write) : 2'b00;
      end
   end

   // R7: faults are exclusive and suppress the address strobe
   assert_fault_excl_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_gp || rsp_pf) |-> (!rsp_pa_ok && !(rsp_gp && rsp_pf)));

   // R7: a request always gets a response one cycle later
   assert_rsp_follows_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R7: no request, no response flags
   assert_rsp_idle_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_pa_ok && !rsp_gp && !rsp_pf));

   // R2: a limit violation is reported as a general-protection fault
   assert_limit_gp_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && limit_err) |=> (rsp_gp && !rsp_pf));

   // R4: descriptor-table accesses never report user privilege
   assert_desc_sup_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && desc) |=> !rsp_pf_code[1]);

endmodule

// File: rtl/v86_xlate_unit.sv
module v86_xlate_unit #(
   parameter int SEG_W     = v86_xlate_pkg::DEF_SEG_W,
   parameter int OFF_W     = v86_xlate_pkg::DEF_OFF_W,
   parameter int SEG_SHIFT = v86_xlate_pkg::DEF_SEG_SHIFT,
   parameter int SIZE_W    = v86_xlate_pkg::DEF_SIZE_W,
   parameter int PAGE_W    = v86_xlate_pkg::DEF_PAGE_W,
   parameter int PHYS_W    = v86_xlate_pkg::DEF_PHYS_W,
   localparam int LIN_W    = SEG_W + SEG_SHIFT,
   localparam int PAGES_W  = LIN_W - PAGE_W,
   localparam int FRAME_W  = PHYS_W - PAGE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [SEG_W-1:0]   req_seg,
   input  logic [OFF_W-1:0]   req_off,
   input  logic [SIZE_W-1:0]  req_size,
   input  logic               req_write,
   input  logic               req_user,
   input  logic               req_desc,
   input  logic               fill_valid,
   input  logic [PAGES_W-1:0] fill_page,
   input  logic [FRAME_W-1:0] fill_frame,
   input  logic               fill_present,
   input  logic               cr3_wr,
   output logic               rsp_valid,
   output logic               rsp_pa_ok,
   output logic [PHYS_W-1:0]  rsp_paddr,
   output logic               rsp_gp,
   output logic               rsp_pf,
   output logic [1:0]         rsp_pf_code
);

   if (PAGE_W < 1 || PAGE_W >= LIN_W) begin : g_bad_page
      $error("v86_xlate_unit: PAGE_W must lie inside the linear width");
   end
   if (PHYS_W <= PAGE_W) begin : g_bad_phys
      $error("v86_xlate_unit: PHYS_W must exceed PAGE_W");
   end

   logic [LIN_W-1:0]   lin;
   logic               limit_err;
   logic               hit;
   logic [FRAME_W-1:0] frame;
   logic [PHYS_W-1:0]  paddr;

   v86_lin_former #(
      .SEG_W     (SEG_W),
      .OFF_W     (OFF_W),
      .SEG_SHIFT (SEG_SHIFT),
      .SIZE_W    (SIZE_W),
      .LIN_W     (LIN_W)
   ) u_lin (
      .seg       (req_seg),
      .off       (req_off),
      .size_m1   (req_size),
      .lin       (lin),
      .limit_err (limit_err)
   );

   v86_page_cache #(
      .PAGES_W (PAGES_W),
      .FRAME_W (FRAME_W)
   ) u_map (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush        (cr3_wr),
      .fill_en      (fill_valid),
      .fill_idx     (fill_page),
      .fill_frame   (fill_frame),
      .fill_present (fill_present),
      .rd_idx       (lin[LIN_W-1:PAGE_W]),
      .rd_hit       (hit),
      .rd_frame     (frame)
   );

   assign paddr = {frame, lin[PAGE_W-1:0]};

   v86_rsp_stage #(
      .PHYS_W (PHYS_W)
   ) u_rsp (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .limit_err   (limit_err),
      .hit         (hit),
      .paddr_in    (paddr),
      .user        (req_user),
      .desc        (req_desc),
      .write       (req_write),
      .rsp_valid   (rsp_valid),
      .rsp_pa_ok   (rsp_pa_ok),
      .rsp_paddr   (rsp_paddr),
      .rsp_gp      (rsp_gp),
      .rsp_pf      (rsp_pf),
      .rsp_pf_code (rsp_pf_code)
   );

   // R5: a request racing a base-register write never translates
   assert_cr3_miss_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cr3_wr) |=> !rsp_pa_ok);

   // R1: a translated address keeps the in-page offset of the request
   assert_page_off_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_pa_ok |-> (rsp_paddr[PAGE_W-1:0] == $past(lin[PAGE_W-1:0])));

endmodule

// File: tb/v86_xlate_unit_test.sv
module v86_xlate_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_seg = '0;
   logic [15:0] req_off = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        req_desc = 1'b0;
   logic        fill_valid = 1'b0;
   logic [7:0]  fill_page = '0;
   logic [19:0] fill_frame = '0;
   logic        fill_present = 1'b0;
   logic        cr3_wr = 1'b0;
   logic        rsp_valid, rsp_pa_ok, rsp_gp, rsp_pf;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_pf_code;

   int nchk = 0;
   int nerr = 0;

   // bench view of the table
   logic [19:0] m_frame [256];
   logic        m_ok    [256];

   always #4 clk = ~clk;

   v86_xlate_unit uut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_seg (req_seg), .req_off (req_off),
      .req_size (req_size), .req_write (req_write), .req_user (req_user),
      .req_desc (req_desc),
      .fill_valid (fill_valid), .fill_page (fill_page),
      .fill_frame (fill_frame), .fill_present (fill_present),
      .cr3_wr (cr3_wr),
      .rsp_valid (rsp_valid), .rsp_pa_ok (rsp_pa_ok), .rsp_paddr (rsp_paddr),
      .rsp_gp (rsp_gp), .rsp_pf (rsp_pf), .rsp_pf_code (rsp_pf_code)
   );

   // vector: seg[39:24] off[23:8] size[7:6] wr[5] user[4] desc[3] kind[1:0]
   // kind: 0 translated, 1 general protection, 2 page fault
   localparam logic [39:0] VEC [12] = '{
      {16'h1200, 16'h0345, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
      {16'h2000, 16'h3FFF, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0},
      {16'h3400, 16'h0010, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2},
      {16'h3400, 16'h0000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2},
      {16'h5000, 16'h0000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2},
      {16'h1000, 16'hFFFF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2},
      {16'h1000, 16'hFFFE, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2},
      {16'h1000, 16'hFFFE, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1},
      {16'hFFFF, 16'h0010, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
      {16'hF000, 16'hFFFF, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0},
      {16'h3400, 16'hFFFF, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1},
      {16'h1200, 16'hFFFD, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // caller stands at a negative edge
   task automatic fill(input logic [7:0] pg, input logic [19:0] fr, input logic pres);
      fill_valid = 1'b1; fill_page = pg; fill_frame = fr; fill_present = pres;
      @(negedge clk);
      fill_valid = 1'b0;
      m_frame[pg] = fr;
      m_ok[pg] = pres;
   endtask

   task automatic put_req(input logic [15:0] s, input logic [15:0] o, input logic [1:0] sz,
                          input logic w, input logic u, input logic d);
      req_valid = 1'b1; req_seg = s; req_off = o; req_size = sz;
      req_write = w; req_user = u; req_desc = d;
   endtask

   task automatic step;
      @(negedge clk);
      req_valid = 1'b0; fill_valid = 1'b0; cr3_wr = 1'b0;
   endtask

   task automatic expect_rsp(input string tag, input int kind,
                             input logic [31:0] pa, input logic [1:0] code);
      chk({tag, " valid R7"}, 32'(rsp_valid), 32'd1);
      chk({tag, " gp R2"},    32'(rsp_gp), 32'(kind == 1));
      chk({tag, " pf R3"},    32'(rsp_pf), 32'(kind == 2));
      chk({tag, " pa_ok R7"}, 32'(rsp_pa_ok), 32'(kind == 0));
      chk({tag, " paddr R1"}, rsp_paddr, (kind == 0) ? pa : 32'd0);
      chk({tag, " code R3 R4"}, 32'(rsp_pf_code), (kind == 2) ? 32'(code) : 32'd0);
   endtask

   function automatic logic [31:0] model_pa(input logic [15:0] s, input logic [15:0] o);
      logic [19:0] l;
      l = 20'({s, 4'h0}) + 20'(o);
      return {m_frame[l[19:12]], l[11:0]};
   endfunction

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 256; i++) begin m_frame[i] = '0; m_ok[i] = 1'b0; end

      // R8: outputs quiet during reset
      repeat (3) @(negedge clk);
      chk("reset rsp_valid R8", 32'(rsp_valid), 32'd0);
      chk("reset flags R8", {28'd0, rsp_pa_ok, rsp_gp, rsp_pf, 1'b0}, 32'd0);
      chk("reset paddr R8", rsp_paddr, 32'd0);
      chk("reset code R8", 32'(rsp_pf_code), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: table empty after reset
      put_req(16'h1200, 16'h0345, 2'd0, 1'b0, 1'b0, 1'b0);
      step();
      expect_rsp("after reset R8", 2, 32'd0, 2'b00);

      // R7: idle cycle gives no response
      step();
      chk("idle valid R7", 32'(rsp_valid), 32'd0);

      fill(8'h12, 20'hABCDE, 1'b1);
      fill(8'h23, 20'h00345, 1'b1);
      fill(8'h34, 20'h11111, 1'b0);
      fill(8'hFF, 20'hFFFFF, 1'b1);
      fill(8'h00, 20'h54321, 1'b1);

      for (int v = 0; v < 12; v++) begin
         logic [39:0] e;
         e = VEC[v];
         put_req(e[39:24], e[23:8], e[7:6], e[5], e[4], e[3]);
         step();
         expect_rsp($sformatf("vec%0d", v), int'(e[1:0]),
                    model_pa(e[39:24], e[23:8]), {e[4] & ~e[3], e[5]});
      end

      // R6: refill and request in the same cycle; old entry seen first
      fill_valid = 1'b1; fill_page = 8'h40; fill_frame = 20'h0BEEF; fill_present = 1'b1;
      put_req(16'h4000, 16'h0123, 2'd0, 1'b1, 1'b0, 1'b0);
      step();
      m_frame[8'h40] = 20'h0BEEF; m_ok[8'h40] = 1'b1;
      expect_rsp("same-cycle fill R6", 2, 32'd0, 2'b01);
      put_req(16'h4000, 16'h0123, 2'd0, 1'b1, 1'b0, 1'b0);
      step();
      expect_rsp("next-cycle fill R6", 0, 32'h0BEEF123, 2'b00);

      // R3: reload with present clear removes the mapping
      fill(8'h40, 20'h0BEEF, 1'b0);
      put_req(16'h4000, 16'h0123, 2'd0, 1'b0, 1'b1, 1'b0);
      step();
      expect_rsp("absent reload R3", 2, 32'd0, 2'b10);

      // R5: request concurrent with the base-register write misses
      cr3_wr = 1'b1;
      put_req(16'h1200, 16'h0345, 2'd0, 1'b0, 1'b0, 1'b0);
      step();
      for (int i = 0; i < 256; i++) m_ok[i] = 1'b0;
      expect_rsp("same-cycle flush R5", 2, 32'd0, 2'b00);
      put_req(16'h0000, 16'h0010, 2'd0, 1'b1, 1'b1, 1'b0);
      step();
      expect_rsp("after flush R5", 2, 32'd0, 2'b11);

      // R5: refill concurrent with flush is discarded
      cr3_wr = 1'b1;
      fill_valid = 1'b1; fill_page = 8'h12; fill_frame = 20'h77777; fill_present = 1'b1;
      step();
      put_req(16'h1200, 16'h0345, 2'd0, 1'b0, 1'b0, 1'b0);
      step();
      expect_rsp("fill during flush R5", 2, 32'd0, 2'b00);

      // R1: new task mapping after the flush
      fill(8'h12, 20'h77777, 1'b1);
      put_req(16'h1200, 16'h0345, 2'd0, 1'b0, 1'b0, 1'b0);
      step();
      expect_rsp("new mapping R1", 0, model_pa(16'h1200, 16'h0345), 2'b00);

      finish_run();
   end

endmodule